// File: doc/BRIEF.md
# Shift-Accumulate Post-Processor for a Folded FIR

This block closes a folded FIR datapath. That datapath splits every input sample into 2-bit radix-4 digits and splits the tap set into FOLD sections. A carry-save tree upstream reduces one tap section for one digit to a redundant pair (tree sum and tree carry) plus two leftover carry-in bits each clock. The post-processor takes these per-cycle contributions over a frame of FOLD × DATA_W/2 cycles and produces one full-precision output sample.

The running total is held in redundant form. A pair of carry-save adders folds in the tree outputs each cycle. The two leftover carry-in bits go into the empty low bit of each adder's carry vector. Within one digit the FOLD section results add with equal weight. When the digit index advances, the fed-back pair is arithmetically shifted right by two. The two bits that fall off each vector are kept in low-order shift registers, so the result loses nothing. The first cycle of a frame replaces the fed-back state with the sign-extension correction constant and zero. One cycle after the last accumulation, a carry-propagate adder merges the pair and the output register loads the result with a one-cycle valid pulse.

Top module: `fold_post_accum`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0 and y_o is all zeros until the first frame completes.
- R2: A frame result equals corr_i (taken in the start cycle) plus, for every accumulated cycle, (tsum_i + tcarry_i + cin_a_i + cin_b_i) × 4^d, reduced modulo 2^OUT_W and read as two's complement. tsum_i and tcarry_i are unsigned, and d is the digit index of that cycle.
- R3: valid_o is high for exactly one cycle per completed frame. It rises at the FRAME-th rising edge after the edge that samples start_i, where FRAME = FOLD × DATA_W/2.
- R4: cin_a_i and cin_b_i each add 1 × 4^d to the result in every accumulated cycle in which they are high.
- R5: step_i high in a non-start cycle of a frame raises the digit index by one for that cycle and all later ones. step_i in the start cycle has no effect. A frame carries DATA_W/2 − 1 steps.
- R6: The correction constant enters exactly once per frame: a frame of all-zero inputs yields y_o = corr_i.
- R7: start_i during an unfinished frame abandons it. The abandoned frame produces no valid_o and leaves no trace in the new frame's result.
- R8: Outside a frame (no start_i and no frame running), the data, carry-in and step inputs are ignored. No valid_o appears and the next frame's result is unaffected.
- R9: No precision is lost in the ×1/4 feedback: the result is exact modulo 2^OUT_W for all-ones inputs and for odd values in the lowest digit.
- R10: A new start_i in the cycle right after a frame's last cycle is accepted. Back-to-back frames yield valid pulses FRAME cycles apart, each with its own correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | First accumulation cycle of a frame |
| step_i | input | 1 | Digit index advances in this cycle |
| tsum_i | input | TREE_W | Tree sum vector, unsigned |
| tcarry_i | input | TREE_W | Tree carry vector, unsigned |
| cin_a_i | input | 1 | First leftover carry-in bit |
| cin_b_i | input | 1 | Second leftover carry-in bit |
| corr_i | input | OUT_W | Sign-extension correction constant |
| y_o | output | OUT_W | Output sample, two's complement |
| valid_o | output | 1 | One-cycle pulse marking a new y_o |

## Verification
A wrong digit shift or a lost low-order bit corrupts only the output sample of that frame. The error appears as a value scaled by a power of four, or as a low bits mismatch, exactly FRAME + 1 cycles after start_i. A misplaced carry-in injection shows as an offset of a few units at the weight of the affected digit. A broken frame counter shows as valid_o arriving in the wrong cycle, arriving twice, or arriving after an abandoned frame. The scoreboard catches each of these on the first affected frame. Random frames, corner patterns, restarts and back-to-back frames give each fault a frame in which to show.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    // Number of radix-4 digits in a DATA_W-bit sample.
    function automatic int digit_count(input int data_w);
        return data_w / 2;
    endfunction

    // Bits retained below the accumulator after all digit shifts.
    function automatic int low_width(input int data_w);
        return 2 * (data_w / 2 - 1);
    endfunction

endpackage

// File: rtl/fpa_csa.sv
module fpa_csa #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] c_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] carry_o
);
    logic [WIDTH-2:0] maj;

    // One full-adder cell per bit; the carry vector is shifted up by one
    // and its freed LSB carries the injected bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_cell
        assign sum_o[b] = a_i[b] ^ b_i[b] ^ c_i[b];
        if (b < WIDTH - 1) begin : g_maj
            assign maj[b] = (a_i[b] & b_i[b]) | (a_i[b] & c_i[b]) | (b_i[b] & c_i[b]);
        end
    end

    assign carry_o = {maj, cin_i};
endmodule

// File: rtl/fpa_merge.sv
module fpa_merge #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o
);
    assign sum_o = a_i + b_i;
endmodule

// File: rtl/fold_post_accum.sv
module fold_post_accum #(
    parameter int TAPS   = 16,
    parameter int FOLD   = 2,
    parameter int DATA_W = 10,
    parameter int COEF_W = 10,
    parameter int TREE_W = COEF_W + 1 + $clog2(TAPS / FOLD),
    parameter int OUT_W  = COEF_W + DATA_W + $clog2(TAPS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              step_i,
    input  logic [TREE_W-1:0] tsum_i,
    input  logic [TREE_W-1:0] tcarry_i,
    input  logic              cin_a_i,
    input  logic              cin_b_i,
    input  logic [OUT_W-1:0]  corr_i,
    output logic [OUT_W-1:0]  y_o,
    output logic              valid_o
);
    import fpa_pkg::*;

    localparam int DIG   = digit_count(DATA_W);
    localparam int FRAME = FOLD * DIG;
    localparam int LOW_W = low_width(DATA_W);
    localparam int HI_W  = OUT_W - LOW_W;
    localparam int CNT_W = $clog2(FRAME + 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [OUT_W-1:0] s;
        logic [OUT_W-1:0] c;
        logic [LOW_W-1:0] lo_s;
        logic [LOW_W-1:0] lo_c;
        logic             valid;
        logic [OUT_W-1:0] y;
    } state_t;

    state_t st_d, st_q;

    // Feedback path: x1 or x1/4 (arithmetic), or correction + zero at start.
    logic signed [OUT_W-1:0] s_quarter, c_quarter;
    logic [OUT_W-1:0] fb_s, fb_c;
    logic [OUT_W-1:0] ext_sum, ext_carry;
    logic [OUT_W-1:0] s1, k1, s2, k2;
    logic [OUT_W-1:0] merged;

    assign s_quarter = $signed(st_q.s) >>> 2;
    assign c_quarter = $signed(st_q.c) >>> 2;
    assign fb_s = start_i ? corr_i : (step_i ? s_quarter : st_q.s);
    assign fb_c = start_i ? '0     : (step_i ? c_quarter : st_q.c);
    assign ext_sum   = OUT_W'(tsum_i);
    assign ext_carry = OUT_W'(tcarry_i);

    fpa_csa #(.WIDTH(OUT_W)) u_csa_a (
        .a_i(fb_s), .b_i(fb_c), .c_i(ext_sum), .cin_i(cin_a_i),
        .sum_o(s1), .carry_o(k1)
    );

    fpa_csa #(.WIDTH(OUT_W)) u_csa_b (
        .a_i(s1), .b_i(k1), .c_i(ext_carry), .cin_i(cin_b_i),
        .sum_o(s2), .carry_o(k2)
    );

    fpa_merge #(.WIDTH(OUT_W)) u_merge (
        .a_i({st_q.s[HI_W-1:0], st_q.lo_s}),
        .b_i({st_q.c[HI_W-1:0], st_q.lo_c}),
        .sum_o(merged)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.valid = 1'b0;
        if (start_i) begin
            st_d.run  = (FRAME > 1);
            st_d.done = (FRAME == 1);
            st_d.cnt  = CNT_W'(1);
            st_d.s    = s2;
            st_d.c    = k2;
            st_d.lo_s = '0;
            st_d.lo_c = '0;
        end else if (st_q.run) begin
            st_d.s   = s2;
            st_d.c   = k2;
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (step_i) begin
                st_d.lo_s = {st_q.s[1:0], st_q.lo_s[LOW_W-1:2]};
                st_d.lo_c = {st_q.c[1:0], st_q.lo_c[LOW_W-1:2]};
            end
            if (st_q.cnt == CNT_W'(FRAME - 1)) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end
        end
        if (st_q.done) begin
            st_d.y     = merged;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign y_o     = st_q.y;
    assign valid_o = st_q.valid;

    // R3: the output strobe never lasts two cycles
    p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R3: frame counter never runs past the frame length
    p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CNT_W'(FRAME));

    // R7: a start always opens a fresh frame, never an immediate finish
    p_start_no_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (!st_q.done && st_q.run));

    // R8: idle cycles leave the redundant accumulator untouched
    p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.run && !start_i) |=> ($stable(st_q.s) && $stable(st_q.c)));

    // R9: bits dropped by the x1/4 feedback land in the low-order registers
    p_low_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && !start_i && step_i) |=>
            (st_q.lo_s[LOW_W-1:LOW_W-2] == $past(st_q.s[1:0]) &&
             st_q.lo_c[LOW_W-1:LOW_W-2] == $past(st_q.c[1:0])));
endmodule

// File: tb/tb_fold_post_accum.sv
module tb_fold_post_accum;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS   = 16;
    localparam int FOLD   = 2;
    localparam int DATA_W = 10;
    localparam int COEF_W = 10;
    localparam int TREE_W = COEF_W + 1 + $clog2(TAPS / FOLD);
    localparam int OUT_W  = COEF_W + DATA_W + $clog2(TAPS);
    localparam int DIG    = DATA_W / 2;
    localparam int FRAME  = FOLD * DIG;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0, step = 1'b0;
    logic [TREE_W-1:0] tsum = '0, tcarry = '0;
    logic              cin_a = 1'b0, cin_b = 1'b0;
    logic [OUT_W-1:0]  corr = '0;
    logic [OUT_W-1:0]  y;
    logic              valid;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [OUT_W-1:0] exp_q[$];
    int               due_q[$];
    string            tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fold_post_accum #(.TAPS(TAPS), .FOLD(FOLD), .DATA_W(DATA_W), .COEF_W(COEF_W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step),
        .tsum_i(tsum), .tcarry_i(tcarry), .cin_a_i(cin_a), .cin_b_i(cin_b),
        .corr_i(corr), .y_o(y), .valid_o(valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every valid pulse (R2, R3 timing).
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (exp_q.size() == 0) begin
                check("R3/R7/R8 unexpected valid", 64'(y), 64'hDEAD);
            end else begin
                logic [OUT_W-1:0] e;
                int d;
                string t;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                t = tag_q.pop_front();
                check({t, " value"}, 64'(y), 64'(e));
                check("R3 latency", 64'(cyc), 64'(d));
            end
        end
    end

    // Driver: kind 0 random, 1 zeros, 2 carry-ins only, 3 last digit only,
    // 4 first digit only, 5 all ones. len < FRAME makes an abandoned frame.
    task automatic run_frame(input int kind, input int len, input logic [OUT_W-1:0] c0,
                             input bit gap, input string tag);
        logic [63:0] acc;
        int due;
        acc = 64'(c0);
        due = 0;
        for (int k = 0; k < len; k++) begin
            int dg;
            logic [TREE_W-1:0] s, c;
            logic b0, b1;
            @(negedge clk);
            dg = k / FOLD;
            case (kind)
                1: begin s = '0; c = '0; b0 = 0; b1 = 0; end
                2: begin s = '0; c = '0; b0 = 1; b1 = 1; end
                3: begin s = (dg == DIG - 1) ? TREE_W'(1) : '0; c = '0; b0 = 0; b1 = 0; end
                4: begin s = (dg == 0) ? TREE_W'(3) : '0; c = (dg == 0) ? TREE_W'(1) : '0;
                         b0 = 0; b1 = 0; end
                5: begin s = '1; c = '1; b0 = 1; b1 = 1; end
                default: begin s = TREE_W'($urandom); c = TREE_W'($urandom);
                               b0 = 1'($urandom); b1 = 1'($urandom); end
            endcase
            start  = (k == 0);
            step   = (k == 0) ? 1'b1 : (k % FOLD == 0);  // start-cycle step must be ignored (R5)
            tsum   = s;
            tcarry = c;
            cin_a  = b0;
            cin_b  = b1;
            corr   = (k == 0) ? c0 : OUT_W'($urandom);
            if (k == 0) due = cyc + 1 + FRAME;
            acc = acc + ((64'(s) + 64'(c) + 64'(b0) + 64'(b1)) << (2 * dg));
        end
        if (len == FRAME) begin
            exp_q.push_back(acc[OUT_W-1:0]);
            due_q.push_back(due);
            tag_q.push_back(tag);
        end
        if (gap) begin
            @(negedge clk);
            start = 1'b0;
            step = 1'($urandom);
            tsum = TREE_W'($urandom); tcarry = TREE_W'($urandom);
            cin_a = 1'($urandom); cin_b = 1'($urandom);
        end
    endtask

    task automatic idle_garbage(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            step = 1'($urandom);
            tsum = TREE_W'($urandom); tcarry = TREE_W'($urandom);
            cin_a = 1'($urandom); cin_b = 1'($urandom);
            corr = OUT_W'($urandom);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 64'(valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 64'(valid), 64'd0);
        check("R1 y after reset", 64'(y), 64'd0);

        run_frame(1, FRAME, OUT_W'(24'h00ABCD), 1, "R6 zero data positive corr");
        run_frame(1, FRAME, OUT_W'(24'hFFF000), 1, "R6 zero data negative corr");
        run_frame(2, FRAME, '0, 1, "R4 carry-ins only");
        run_frame(3, FRAME, '0, 1, "R5 last digit only");
        run_frame(4, FRAME, '0, 1, "R5 first digit only");
        run_frame(5, FRAME, OUT_W'($urandom), 1, "R9 all ones");
        for (int i = 0; i < 6; i++) run_frame(0, FRAME, OUT_W'($urandom), 1, "R2 random");

        idle_garbage(15);
        run_frame(0, FRAME, OUT_W'($urandom), 1, "R8 after idle garbage");

        run_frame(0, 4, OUT_W'($urandom), 1, "R7 abandoned");
        run_frame(0, FRAME, OUT_W'($urandom), 1, "R7 after restart");
        run_frame(5, 7, OUT_W'($urandom), 0, "R7 abandoned no gap");
        run_frame(1, FRAME, OUT_W'(24'h000321), 1, "R7 restart clean");

        for (int i = 0; i < 3; i++) run_frame(0, FRAME, OUT_W'($urandom), 0, "R10 back-to-back");
        idle_garbage(FRAME + 5);
        check("R2 all frames produced", 64'(exp_q.size()), 64'd0);
        report();
    end
endmodule